// File: doc/BRIEF.md
# Reset Qualifier and Boot Mode Selector

This block sits between the raw reset, program-strobe and external-access pins and the processor core. It brings all three pin levels into the clock domain through a synchronizer chain. It looks at them once per machine cycle and counts how many consecutive machine cycles reset has been held. The core reset asserts only after reset has been held long enough. Shorter pulses are treated as noise.

While reset is held, the block watches the program-strobe pin for a high-to-low transition. If that transition arrives after reset has already been held for more than a set number of machine cycles, the part leaves reset in external host programming mode. Otherwise it leaves reset in normal run. At release it also decides where code is fetched from. A configuration bit that forbids external boot overrides the external-access strap. Both decisions are captured on the release cycle and then hold until the next core reset.

Top module: `boot_mode_sel`

## Requirements
- R1: After power-on reset, `core_rst` is 1, `host_mode` is 0 and `fetch_internal` is 1 until the first release.
- R2: `core_rst` asserts only once reset has been seen high on at least RST_QUAL_MC (default 2) consecutive machine-cycle samples. A pulse seen on one sample leaves all outputs unchanged.
- R3: `core_rst` deasserts at the first machine-cycle sample that sees reset low. This is at most SYNC_STAGES clocks plus one machine cycle after the pin falls, and never within one clock of it.
- R4: A strobe transition from 1 on one machine-cycle sample to 0 on the next counts as host entry when it occurs while reset is high and the hold count, including the current sample, exceeds HOST_MIN_MC (default 10). The release that follows sets `host_mode` to 1.
- R5: A strobe fall while reset is high but the hold count is at or below HOST_MIN_MC gives `host_mode` 0 at release.
- R6: A reset with no strobe fall leaves reset with `host_mode` 0.
- R7: At release, `fetch_internal` takes the value of the synchronized external-access strap when `cfg_int_only` is 0. Strap 1 selects internal fetch and strap 0 selects external fetch.
- R8: With `cfg_int_only` at 1 on the release cycle, `fetch_internal` is 1 whatever the strap level.
- R9: Between a release and the next core reset, `host_mode` and `fetch_internal` do not change. Toggling the strap, the configuration bit or the strobe has no effect on them.
- R10: The hold counter saturates instead of wrapping. After a hold of 40 machine cycles, a strobe fall near the end still counts as host entry.
- R11: Each assertion of `core_rst` clears `host_mode` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw reset pin, active high |
| strobe_pin | input | 1 | Raw program-strobe pin, mode-entry input during reset |
| ext_acc_pin | input | 1 | Raw external-access strap, 1 = internal, 0 = external |
| cfg_int_only | input | 1 | Configuration bit forbidding external boot |
| core_rst | output | 1 | Qualified reset to the core, active high |
| host_mode | output | 1 | External host programming mode selected |
| fetch_internal | output | 1 | 1 = fetch code from internal memory |

## Verification
Each pin change reaches the decision logic two clocks later, through the synchronizer. It then waits for the next machine-cycle tick. The outputs change on that tick's edge, so a reset release or qualification appears between 3 and 14 clocks after the pin moves. The bench's reference model shifts the pins through its own two-deep delay and keeps its own machine-cycle count. The outputs are compared with it at every falling clock edge. Directed checks are placed at least three machine cycles after a stimulus, or within one clock of it when the point is that nothing has changed yet. Strobe falls are placed several machine cycles away from the HOST_MIN_MC threshold, so the tick phase cannot move them across it.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

   // Boot decision captured on the release cycle
   typedef struct packed {
      logic host;
      logic fetch_int;
   } boot_dec_t;

   localparam boot_dec_t BOOT_DEC_RESET = '{host: 1'b0, fetch_int: 1'b1};

   // Width needed to hold a count strictly above the host threshold
   function automatic int hold_cnt_width(input int host_min);
      return $clog2(host_min + 2);
   endfunction

endpackage

// File: rtl/bsel_sync.sv
module bsel_sync #(
   parameter int                WIDTH   = 1,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
      end else begin
         pipe <= {pipe[STAGES-2:0], d};
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/bsel_mc_tick.sv
module bsel_mc_tick #(
   parameter int CLKS_PER_MC = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (CLKS_PER_MC == 1) begin : g_every_clk
         logic run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run_q <= 1'b0;
            else        run_q <= 1'b1;
         end
         assign tick = run_q;
      end else begin : g_divider
         localparam int               DIV_W = $clog2(CLKS_PER_MC);
         localparam logic [DIV_W-1:0] LAST  = DIV_W'(CLKS_PER_MC - 1);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                    div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/bsel_hold_ctr.sv
module bsel_hold_ctr #(
   parameter int CNT_W       = 4,
   parameter int RST_QUAL_MC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rst_lvl,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_next,
   output logic             qualified
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] QUAL_V  = CNT_W'(RST_QUAL_MC);

   always_comb begin
      if (!rst_lvl)            cnt_next = '0;
      else if (cnt == CNT_MAX) cnt_next = cnt;
      else                     cnt_next = cnt + 1'b1;
   end

   assign qualified = rst_lvl && (cnt_next >= QUAL_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt_next;
   end

endmodule

// File: rtl/bsel_mode_dec.sv
module bsel_mode_dec
   import boot_sel_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int HOST_MIN_MC = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rst_lvl,
   input  logic             strb_lvl,
   input  logic             ea_lvl,
   input  logic             cfg_int_only,
   input  logic [CNT_W-1:0] cnt_next,
   input  logic             qualified,
   output logic             core_rst,
   output logic             host_req,
   output boot_dec_t        dec
);

   localparam logic [CNT_W-1:0] HOST_V = CNT_W'(HOST_MIN_MC);

   logic strb_prev;
   logic strb_fall;
   logic release_now;

   assign strb_fall   = strb_prev && !strb_lvl;
   assign release_now = !rst_lvl && core_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_prev <= 1'b0;
         host_req  <= 1'b0;
      end else if (tick) begin
         strb_prev <= strb_lvl;
         if (!rst_lvl)
            host_req <= 1'b0;
         else if (strb_fall && (cnt_next > HOST_V))
            host_req <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_rst <= 1'b1;
         dec      <= BOOT_DEC_RESET;
      end else if (tick) begin
         if (qualified) begin
            core_rst <= 1'b1;
            dec.host <= 1'b0;
         end else if (release_now) begin
            core_rst      <= 1'b0;
            dec.host      <= host_req;
            dec.fetch_int <= cfg_int_only | ea_lvl;
         end
      end
   end

endmodule

// File: rtl/boot_mode_sel.sv
module boot_mode_sel
   import boot_sel_pkg::*;
#(
   parameter int CLKS_PER_MC = 12,
   parameter int SYNC_STAGES = 2,
   parameter int RST_QUAL_MC = 2,
   parameter int HOST_MIN_MC = 10
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_pin,
   input  logic strobe_pin,
   input  logic ext_acc_pin,
   input  logic cfg_int_only,
   output logic core_rst,
   output logic host_mode,
   output logic fetch_internal
);

   localparam int CNT_W = hold_cnt_width(HOST_MIN_MC);

   // Elaboration-time parameter checks
   generate
      if (CLKS_PER_MC < 1) begin : g_bad_mc
         $error("CLKS_PER_MC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (RST_QUAL_MC < 1) begin : g_bad_qual
         $error("RST_QUAL_MC must be at least 1");
      end
      if (HOST_MIN_MC < RST_QUAL_MC) begin : g_bad_host
         $error("HOST_MIN_MC must not be below RST_QUAL_MC");
      end
   endgenerate

   // Pin order in the synchronized vector: {strap, strobe, reset}
   logic [2:0] pins_s;
   logic       rst_s, strb_s, ea_s;
   logic       mc_tick;
   logic [CNT_W-1:0] hold_cnt, hold_next;
   logic       hold_ok;
   logic       host_req;
   boot_dec_t  dec;

   bsel_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b110)
   ) u_sync (
      .clk  (clk),
      .rst_n(por_n),
      .d    ({ext_acc_pin, strobe_pin, rst_pin}),
      .q    (pins_s)
   );

   assign rst_s  = pins_s[0];
   assign strb_s = pins_s[1];
   assign ea_s   = pins_s[2];

   bsel_mc_tick #(
      .CLKS_PER_MC(CLKS_PER_MC)
   ) u_tick (
      .clk  (clk),
      .rst_n(por_n),
      .tick (mc_tick)
   );

   bsel_hold_ctr #(
      .CNT_W      (CNT_W),
      .RST_QUAL_MC(RST_QUAL_MC)
   ) u_hold (
      .clk      (clk),
      .rst_n    (por_n),
      .tick     (mc_tick),
      .rst_lvl  (rst_s),
      .cnt      (hold_cnt),
      .cnt_next (hold_next),
      .qualified(hold_ok)
   );

   bsel_mode_dec #(
      .CNT_W      (CNT_W),
      .HOST_MIN_MC(HOST_MIN_MC)
   ) u_dec (
      .clk         (clk),
      .rst_n       (por_n),
      .tick        (mc_tick),
      .rst_lvl     (rst_s),
      .strb_lvl    (strb_s),
      .ea_lvl      (ea_s),
      .cfg_int_only(cfg_int_only),
      .cnt_next    (hold_next),
      .qualified   (hold_ok),
      .core_rst    (core_rst),
      .host_req    (host_req),
      .dec         (dec)
   );

   assign host_mode      = dec.host;
   assign fetch_internal = dec.fetch_int;

endmodule

// File: rtl/boot_mode_sel_chk.sv
module boot_mode_sel_chk #(
   parameter int CNT_W       = 4,
   parameter int RST_QUAL_MC = 2,
   parameter int HOST_MIN_MC = 10
) (
   input logic             clk,
   input logic             por_n,
   input logic             cfg_int_only,
   input logic             core_rst,
   input logic             host_mode,
   input logic             fetch_internal,
   input logic             mc_tick,
   input logic [CNT_W-1:0] hold_cnt,
   input logic             host_req
);

   localparam logic [CNT_W-1:0] QUAL_V = CNT_W'(RST_QUAL_MC);
   localparam logic [CNT_W-1:0] HOST_V = CNT_W'(HOST_MIN_MC);

   // R2: core reset only rises once the hold count has reached qualification
   p_qual_before_reset_r2: assert property (@(posedge clk) disable iff (!por_n)
      $rose(core_rst) |-> (hold_cnt >= QUAL_V));

   // R3: core reset moves only on a machine-cycle edge
   p_reset_on_tick_r3: assert property (@(posedge clk) disable iff (!por_n)
      !$stable(core_rst) |-> $past(mc_tick));

   // R4: host mode turns on only together with a release
   p_host_at_release_r4: assert property (@(posedge clk) disable iff (!por_n)
      $rose(host_mode) |-> $fell(core_rst));

   // R4: a host request is recorded only past the hold threshold
   p_host_req_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
      $rose(host_req) |-> (hold_cnt > HOST_V));

   // R8: forbidding external boot forces internal fetch at release
   p_int_only_r8: assert property (@(posedge clk) disable iff (!por_n)
      ($fell(core_rst) && $past(cfg_int_only)) |-> fetch_internal);

   // R9: decisions are frozen while out of reset
   p_frozen_r9: assert property (@(posedge clk) disable iff (!por_n)
      (!core_rst && !$past(core_rst)) |-> ($stable(host_mode) && $stable(fetch_internal)));

   // R11: entering core reset drops host mode
   p_host_clear_r11: assert property (@(posedge clk) disable iff (!por_n)
      $rose(core_rst) |-> !host_mode);

endmodule

bind boot_mode_sel boot_mode_sel_chk #(
   .CNT_W      (CNT_W),
   .RST_QUAL_MC(RST_QUAL_MC),
   .HOST_MIN_MC(HOST_MIN_MC)
) u_chk (
   .clk           (clk),
   .por_n         (por_n),
   .cfg_int_only  (cfg_int_only),
   .core_rst      (core_rst),
   .host_mode     (host_mode),
   .fetch_internal(fetch_internal),
   .mc_tick       (mc_tick),
   .hold_cnt      (hold_cnt),
   .host_req      (host_req)
);

// File: tb/test_boot_mode_sel.sv
`timescale 1ns/1ps
module test_boot_mode_sel;

   localparam int MC        = 12;
   localparam int QUAL      = 2;
   localparam int HOST_MIN  = 10;
   localparam int WATCHDOG  = 100000;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic rst_pin = 1'b0;
   logic strobe_pin = 1'b1;
   logic ext_acc_pin = 1'b1;
   logic cfg_int_only = 1'b0;
   logic core_rst, host_mode, fetch_internal;

   always #4 clk = ~clk;   // 125 MHz

   boot_mode_sel i_boot_mode_sel (
      .clk           (clk),
      .por_n         (por_n),
      .rst_pin       (rst_pin),
      .strobe_pin    (strobe_pin),
      .ext_acc_pin   (ext_acc_pin),
      .cfg_int_only  (cfg_int_only),
      .core_rst      (core_rst),
      .host_mode     (host_mode),
      .fetch_internal(fetch_internal)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   string phase = "R1";
   bit    done  = 0;

   // ---------------- behavioural reference model ----------------
   int m_div, m_cnt;
   bit m_r[$], m_s[$], m_e[$];
   bit m_sprev, m_req, m_core, m_host, m_fetch;

   always @(posedge clk) begin
      if (!por_n) begin
         m_div = 0; m_cnt = 0;
         m_r = '{0, 0}; m_s = '{1, 1}; m_e = '{1, 1};
         m_sprev = 0; m_req = 0; m_core = 1; m_host = 0; m_fetch = 1;
      end else begin
         bit r, s, tk;
         int nc;
         r  = m_r[0];
         s  = m_s[0];
         tk = (m_div == MC - 1);
         m_div = tk ? 0 : m_div + 1;
         if (tk) begin
            if (r) begin
               nc = (m_cnt < 1000) ? m_cnt + 1 : m_cnt;
               if (m_sprev && !s && nc > HOST_MIN) m_req = 1;
               if (nc >= QUAL) begin
                  m_core = 1; m_host = 0;
               end
            end else begin
               nc = 0;
               if (m_core) begin
                  m_core  = 0;
                  m_host  = m_req;
                  m_fetch = cfg_int_only | m_e[0];
               end
               m_req = 0;
            end
            m_sprev = s;
            m_cnt   = nc;
         end
         void'(m_r.pop_front()); m_r.push_back(rst_pin);
         void'(m_s.pop_front()); m_s.push_back(strobe_pin);
         void'(m_e.pop_front()); m_e.push_back(ext_acc_pin);
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (por_n && cyc > 2 && !done) begin
         chk(phase, "model core_rst", core_rst, m_core);
         chk(phase, "model host_mode", host_mode, m_host);
         chk(phase, "model fetch_internal", fetch_internal, m_fetch);
      end
   end

   task automatic summary();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
         summary();
      end
   end

   task automatic wait_mc(input int n);
      repeat (n * MC) @(negedge clk);
   endtask

   // Hold reset for hold_mc machine cycles; fall strobe at fall_mc (<0: never)
   task automatic pulse_reset(input int hold_mc, input int fall_mc);
      @(negedge clk);
      strobe_pin = 1'b1;
      rst_pin    = 1'b1;
      for (int i = 0; i < hold_mc; i++) begin
         if (i == fall_mc) strobe_pin = 1'b0;
         wait_mc(1);
      end
      rst_pin = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "core_rst in por", core_rst, 1'b1);
      por_n = 1'b1;
      @(negedge clk);
      chk("R1", "core_rst after por", core_rst, 1'b1);
      chk("R1", "host_mode after por", host_mode, 1'b0);
      chk("R1", "fetch_internal after por", fetch_internal, 1'b1);
      wait_mc(3);

      // R6 / R2 / R3: plain reset, no strobe fall
      phase = "R6";
      pulse_reset(15, -1);
      chk("R3", "core_rst one clock after pin fall", core_rst, 1'b1);
      wait_mc(3);
      chk("R3", "core_rst released", core_rst, 1'b0);
      chk("R6", "host_mode normal", host_mode, 1'b0);
      chk("R7", "fetch with strap 1", fetch_internal, 1'b1);

      // R4 / R7: late strobe fall, external strap
      phase = "R4";
      ext_acc_pin = 1'b0;
      pulse_reset(18, 14);
      wait_mc(3);
      chk("R4", "host_mode after late fall", host_mode, 1'b1);
      chk("R7", "fetch with strap 0", fetch_internal, 1'b0);

      // R11: new reset clears host mode
      phase = "R11";
      @(negedge clk);
      strobe_pin = 1'b1;
      rst_pin    = 1'b1;
      wait_mc(4);
      chk("R11", "core_rst during hold", core_rst, 1'b1);
      chk("R11", "host_mode cleared", host_mode, 1'b0);
      rst_pin = 1'b0;
      wait_mc(3);

      // R5: early strobe fall
      phase = "R5";
      ext_acc_pin = 1'b1;
      pulse_reset(14, 5);
      wait_mc(3);
      chk("R5", "host_mode after early fall", host_mode, 1'b0);

      // R8: configuration overrides external strap
      phase = "R8";
      ext_acc_pin  = 1'b0;
      cfg_int_only = 1'b1;
      pulse_reset(6, -1);
      wait_mc(3);
      chk("R8", "fetch forced internal", fetch_internal, 1'b1);

      // R9: inputs toggled after release have no effect
      phase = "R9";
      cfg_int_only = 1'b0;
      ext_acc_pin  = 1'b1;
      strobe_pin   = 1'b0;
      wait_mc(2);
      strobe_pin   = 1'b1;
      ext_acc_pin  = 1'b0;
      wait_mc(2);
      chk("R9", "fetch_internal frozen", fetch_internal, 1'b1);
      chk("R9", "host_mode frozen", host_mode, 1'b0);

      // R2: single-sample reset pulse is ignored
      phase = "R2";
      rst_pin = 1'b1;
      wait_mc(1);
      rst_pin = 1'b0;
      chk("R2", "core_rst during short pulse", core_rst, 1'b0);
      wait_mc(3);
      chk("R2", "core_rst after short pulse", core_rst, 1'b0);
      chk("R2", "fetch_internal after short pulse", fetch_internal, 1'b1);

      // R10: long hold saturates the counter
      phase = "R10";
      pulse_reset(40, 38);
      wait_mc(3);
      chk("R10", "host_mode after long hold", host_mode, 1'b1);
      chk("R10", "fetch after long hold", fetch_internal, 1'b0);

      wait_mc(2);
      summary();
   end

endmodule